// File: doc/BRIEF.md
# Calendar Time-of-Day Counter

This block keeps wall-clock time and date as seconds, minutes, hours, day of week, day of month, month and a two-digit year. An external one-second strobe advances it. A 32.768 kHz base strobe times a short settle window between the advance and the moment the visible field bytes take their new values. The host sees every field as a byte whose form is set by two mode inputs: packed BCD or plain binary, and 12-hour or 24-hour hours. Fields are written one byte at a time through a select and data port. The same port loads three alarm bytes.

Each accepted second raises an update-in-progress flag, advances the internal binary counter and starts the settle window. When the window closes, the block re-encodes the counter into the visible bytes. In the same cycle it compares the three alarm bytes, pulses update-ended, pulses alarm-match when every alarm byte matches, and drops the flag. A hold input freezes the time: ticks are skipped and field writes stay in the visible bytes only. Releasing the hold copies those bytes into the counter.

Top module: `rtc_cal_top`

## Requirements
- R1: After reset the field bytes read seconds 00, minutes 00, hours 00, weekday 00, day 01, month 01, year 00. Update-in-progress, update-ended and alarm-match are low, and all three alarm bytes are 00.
- R2: A second tick is accepted only when `oscSel` equals 3'b010. With any other value the tick is skipped: no flag, no update-ended pulse, and the field bytes are unchanged.
- R3: `updInProg` is high the cycle after an accepted tick. It falls together with a one-cycle `updEnded` pulse on the edge of the eighth following `baseTick`. The field bytes change on that same edge.
- R4: With `binMode` high, every field byte holds the plain binary value. With it low, the byte holds packed BCD, with tens in bits 7:4 and units in bits 3:0.
- R5: With `hr24Mode` high, the hours byte holds 0 to 23. With it low, bits 6:0 hold the hour modulo 12 and bit 7 is set for hours 12 to 23.
- R6: Seconds wrap at 60 into minutes, minutes wrap at 60 into hours, and hours wrap at 24. On that last wrap the weekday goes 6 to 0, the day passes the month length to 1, the month passes 12 to 1, and the year goes 99 to 00.
- R7: February has 29 days when 2000 plus the year is divisible by 4 and is either not divisible by 100 or divisible by 400. Otherwise it has 28 days.
- R8: A month value outside 1 to 12 is given 31 days.
- R9: While `setMode` is high, ticks are skipped and field writes (select codes: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year) change only the visible bytes. When `setMode` falls, the counter is loaded from the bytes. A field write with `setMode` low loads the counter from the bytes one cycle after the write.
- R10: Alarm bytes are written with select 8 (seconds), 9 (minutes) and 10 (hours). An alarm byte with bits 7:6 both set matches any value; any other alarm byte must equal the new field byte. `alarmHit` pulses with `updEnded` when all three alarm bytes match.
- R11: Raising `setMode` clears `updInProg` on the next edge.
- R12: A second tick that arrives while an update window is still open is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| secTick | input | 1 | One-second strobe |
| baseTick | input | 1 | 32.768 kHz strobe that times the settle window |
| oscSel | input | 3 | Divider field; 3'b010 means running |
| binMode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24Mode | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM bit |
| setMode | input | 1 | Hold: freezes the counter, writes held |
| wrEn | input | 1 | Field write strobe |
| wrSel | input | 4 | Field select for a write |
| wrData | input | 8 | Byte written |
| secReg | output | 8 | Seconds byte |
| minReg | output | 8 | Minutes byte |
| hourReg | output | 8 | Hours byte |
| dowReg | output | 8 | Weekday byte |
| domReg | output | 8 | Day-of-month byte |
| monReg | output | 8 | Month byte |
| yearReg | output | 8 | Year byte |
| updInProg | output | 1 | Update in progress |
| updEnded | output | 1 | One-cycle pulse when the bytes refresh |
| alarmHit | output | 1 | One-cycle pulse on alarm match |

## Verification
The assertions check the flag protocol on every cycle. The flag may only rise after an accepted tick on a running divider. It stays down while the divider is halted and falls on the next edge after hold is raised. Update-ended is a lone pulse with the flag already low, alarm-match never appears without update-ended, and the visible bytes stay still under hold unless written. The calendar arithmetic needs the bench's scenarios to show it: the BCD and 12-hour encodings, the rollover chain through month and year ends, the leap-year and out-of-range-month lengths, load-on-release, dropped ticks and alarm matching.

// File: rtl/rtc_cal_pkg.sv
`timescale 1ns/1ps
package rtc_cal_pkg;

  localparam int FieldCount = 7;
  localparam int AlarmCount = 3;
  localparam int AlarmBase  = 8;

  typedef struct packed {
    logic [6:0] sec;
    logic [6:0] min;
    logic [6:0] hour;
    logic [6:0] dow;
    logic [6:0] dom;
    logic [6:0] mon;
    logic [6:0] year;
  } calTimeT;

  typedef struct packed {
    logic advance;
    logic refresh;
    logic load;
  } calStrobeT;

  function automatic logic [7:0] fmtVal(input logic [6:0] v, input logic binMode);
    logic [6:0] tens;
    logic [6:0] ones;
    tens = v / 7'd10;
    ones = v % 7'd10;
    return binMode ? {1'b0, v} : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] parseVal(input logic [7:0] b, input logic binMode);
    logic [7:0] acc;
    acc = {4'd0, b[7:4]} * 8'd10 + {4'd0, b[3:0]};
    return binMode ? b[6:0] : acc[6:0];
  endfunction

  function automatic logic [7:0] fmtHour(input logic [6:0] h, input logic binMode,
                                         input logic hr24);
    logic [6:0] h12;
    h12 = h % 7'd12;
    return hr24 ? fmtVal(h, binMode) : (fmtVal(h12, binMode) | {(h >= 7'd12), 7'd0});
  endfunction

  function automatic logic [6:0] parseHour(input logic [7:0] b, input logic binMode,
                                           input logic hr24);
    logic [6:0] low;
    low = parseVal({1'b0, b[6:0]}, binMode);
    if (hr24) return parseVal(b, binMode);
    return b[7] ? low + 7'd12 : low;
  endfunction

  function automatic logic leapYear(input logic [6:0] y, input int baseYear);
    int full;
    full = baseYear + int'(y);
    return ((full % 4) == 0) && (((full % 100) != 0) || ((full % 400) == 0));
  endfunction

  function automatic logic [6:0] monthLen(input logic [6:0] mon, input logic leap);
    case (mon)
      7'd2:                       return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_cal_step.sv
`timescale 1ns/1ps
module rtc_cal_step
  import rtc_cal_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  calTimeT cur,
  output calTimeT nxt
);

  logic [6:0] lastDay;
  logic       secWrap;
  logic       minWrap;
  logic       hourWrap;
  logic       domWrap;

  always_comb begin
    lastDay  = monthLen(cur.mon, leapYear(cur.year, BASE_YEAR));
    secWrap  = cur.sec >= 7'd59;
    minWrap  = secWrap && (cur.min >= 7'd59);
    hourWrap = minWrap && (cur.hour >= 7'd23);
    domWrap  = hourWrap && (cur.dom >= lastDay);

    nxt     = cur;
    nxt.sec = secWrap ? 7'd0 : cur.sec + 7'd1;
    if (secWrap)
      nxt.min = (cur.min >= 7'd59) ? 7'd0 : cur.min + 7'd1;
    if (minWrap)
      nxt.hour = (cur.hour >= 7'd23) ? 7'd0 : cur.hour + 7'd1;
    if (hourWrap) begin
      nxt.dow = (cur.dow >= 7'd6) ? 7'd0 : cur.dow + 7'd1;
      nxt.dom = (cur.dom >= lastDay) ? 7'd1 : cur.dom + 7'd1;
    end
    if (domWrap) begin
      nxt.mon = (cur.mon >= 7'd12) ? 7'd1 : cur.mon + 7'd1;
      if (cur.mon >= 7'd12)
        nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
    end
  end

endmodule

// File: rtl/rtc_cal_ctrl.sv
`timescale 1ns/1ps
module rtc_cal_ctrl
  import rtc_cal_pkg::*;
#(
  parameter int         DELAY_TICKS = 8,
  parameter logic [2:0] RUN_CODE    = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       secTick,
  input  logic       baseTick,
  input  logic [2:0] oscSel,
  input  logic       setMode,
  input  logic       timeWrite,
  output calStrobeT  stb,
  output logic       updInProg
);

  localparam int CntW = $clog2(DELAY_TICKS + 1);
  localparam logic [CntW-1:0] LastCnt = CntW'(DELAY_TICKS - 1);

  logic            busy;
  logic [CntW-1:0] waitCnt;
  logic            setPrev;
  logic            loadPend;

  always_comb begin
    stb.load    = loadPend;
    stb.advance = secTick && (oscSel == RUN_CODE) && !setMode && !busy && !loadPend;
    stb.refresh = busy && baseTick && (waitCnt == LastCnt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      waitCnt   <= '0;
      setPrev   <= 1'b0;
      loadPend  <= 1'b0;
      updInProg <= 1'b0;
    end else begin
      setPrev  <= setMode;
      loadPend <= !setMode && (timeWrite || setPrev);

      if (stb.advance) begin
        busy    <= 1'b1;
        waitCnt <= '0;
      end else if (stb.refresh) begin
        busy <= 1'b0;
      end else if (busy && baseTick) begin
        waitCnt <= waitCnt + 1'b1;
      end

      if (setMode || stb.refresh)
        updInProg <= 1'b0;
      else if (stb.advance)
        updInProg <= 1'b1;
    end
  end

endmodule

// File: rtl/rtc_cal_dp.sv
`timescale 1ns/1ps
module rtc_cal_dp
  import rtc_cal_pkg::*;
#(
  parameter int BASE_YEAR = 2000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  calStrobeT                    stb,
  input  logic                         binMode,
  input  logic                         hr24Mode,
  input  logic                         setMode,
  input  logic                         wrEn,
  input  logic [3:0]                   wrSel,
  input  logic [7:0]                   wrData,
  output logic [FieldCount-1:0][7:0]   fieldImg,
  output logic                         updEnded,
  output logic                         alarmHit
);

  calTimeT cnt;
  calTimeT cntNext;
  calTimeT decoded;
  logic [FieldCount-1:0][7:0] encB;
  logic [AlarmCount-1:0][7:0] almQ;
  logic [AlarmCount-1:0]      almOk;
  logic                       imgWrite;
  logic                       almWrite;
  logic [3:0]                 almIdx;

  rtc_cal_step #(.BASE_YEAR(BASE_YEAR)) u_step (
    .cur (cnt),
    .nxt (cntNext)
  );

  always_comb begin
    encB[0] = fmtVal(cnt.sec, binMode);
    encB[1] = fmtVal(cnt.min, binMode);
    encB[2] = fmtHour(cnt.hour, binMode, hr24Mode);
    encB[3] = fmtVal(cnt.dow, binMode);
    encB[4] = fmtVal(cnt.dom, binMode);
    encB[5] = fmtVal(cnt.mon, binMode);
    encB[6] = fmtVal(cnt.year, binMode);

    decoded.sec  = parseVal(fieldImg[0], binMode);
    decoded.min  = parseVal(fieldImg[1], binMode);
    decoded.hour = parseHour(fieldImg[2], binMode, hr24Mode);
    decoded.dow  = parseVal(fieldImg[3], binMode);
    decoded.dom  = parseVal(fieldImg[4], binMode);
    decoded.mon  = parseVal(fieldImg[5], binMode);
    decoded.year = parseVal(fieldImg[6], binMode);

    imgWrite = wrEn && (wrSel < 4'(FieldCount));
    almIdx   = wrSel - 4'(AlarmBase);
    almWrite = wrEn && (wrSel >= 4'(AlarmBase)) && (almIdx < 4'(AlarmCount));
  end

  for (genvar k = 0; k < AlarmCount; k++) begin : g_alarm
    assign almOk[k] = (almQ[k][7:6] == 2'b11) || (almQ[k] == encB[k]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '{sec: 7'd0, min: 7'd0, hour: 7'd0, dow: 7'd0,
                    dom: 7'd1, mon: 7'd1, year: 7'd0};
      for (int i = 0; i < FieldCount; i++)
        fieldImg[i] <= ((i == 4) || (i == 5)) ? 8'h01 : 8'h00;
      almQ     <= '0;
      updEnded <= 1'b0;
      alarmHit <= 1'b0;
    end else begin
      if (stb.load)
        cnt <= decoded;
      else if (stb.advance)
        cnt <= cntNext;

      updEnded <= stb.refresh;
      alarmHit <= stb.refresh && (&almOk);

      if (stb.refresh && !setMode)
        fieldImg <= encB;
      if (imgWrite)
        fieldImg[wrSel[2:0]] <= wrData;
      if (almWrite)
        almQ[almIdx[1:0]] <= wrData;
    end
  end

endmodule

// File: rtl/rtc_cal_top.sv
`timescale 1ns/1ps
module rtc_cal_top
  import rtc_cal_pkg::*;
#(
  parameter int         DELAY_TICKS = 8,
  parameter int         BASE_YEAR   = 2000,
  parameter logic [2:0] RUN_CODE    = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       secTick,
  input  logic       baseTick,
  input  logic [2:0] oscSel,
  input  logic       binMode,
  input  logic       hr24Mode,
  input  logic       setMode,
  input  logic       wrEn,
  input  logic [3:0] wrSel,
  input  logic [7:0] wrData,
  output logic [7:0] secReg,
  output logic [7:0] minReg,
  output logic [7:0] hourReg,
  output logic [7:0] dowReg,
  output logic [7:0] domReg,
  output logic [7:0] monReg,
  output logic [7:0] yearReg,
  output logic       updInProg,
  output logic       updEnded,
  output logic       alarmHit
);

  calStrobeT                  stb;
  logic [FieldCount-1:0][7:0] fieldImg;
  logic                       timeWrite;

  assign timeWrite = wrEn && (wrSel < 4'(FieldCount));

  rtc_cal_ctrl #(.DELAY_TICKS(DELAY_TICKS), .RUN_CODE(RUN_CODE)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .secTick   (secTick),
    .baseTick  (baseTick),
    .oscSel    (oscSel),
    .setMode   (setMode),
    .timeWrite (timeWrite),
    .stb       (stb),
    .updInProg (updInProg)
  );

  rtc_cal_dp #(.BASE_YEAR(BASE_YEAR)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .binMode  (binMode),
    .hr24Mode (hr24Mode),
    .setMode  (setMode),
    .wrEn     (wrEn),
    .wrSel    (wrSel),
    .wrData   (wrData),
    .fieldImg (fieldImg),
    .updEnded (updEnded),
    .alarmHit (alarmHit)
  );

  assign secReg  = fieldImg[0];
  assign minReg  = fieldImg[1];
  assign hourReg = fieldImg[2];
  assign dowReg  = fieldImg[3];
  assign domReg  = fieldImg[4];
  assign monReg  = fieldImg[5];
  assign yearReg = fieldImg[6];

endmodule

// File: rtl/rtc_cal_chk.sv
`timescale 1ns/1ps
module rtc_cal_chk #(
  parameter logic [2:0] RUN_CODE = 3'b010
) (
  input logic       clk,
  input logic       rst_n,
  input logic       secTick,
  input logic [2:0] oscSel,
  input logic       setMode,
  input logic       wrEn,
  input logic [7:0] secReg,
  input logic [7:0] minReg,
  input logic [7:0] hourReg,
  input logic [7:0] dowReg,
  input logic [7:0] domReg,
  input logic [7:0] monReg,
  input logic [7:0] yearReg,
  input logic       updInProg,
  input logic       updEnded,
  input logic       alarmHit
);

  // R2, R3: the flag only rises after an accepted tick on a running divider
  assert_uip_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(updInProg) |-> ($past(secTick) && ($past(oscSel) == RUN_CODE) && !$past(setMode)));

  // R2: a halted divider keeps the flag low
  assert_halt_no_uip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((oscSel != RUN_CODE) && !updInProg) |=> !updInProg);

  // R3: update-ended is a single-cycle pulse
  assert_ended_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    updEnded |=> !updEnded);

  // R3: the flag is already low when update-ended shows
  assert_ended_flag_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    updEnded |-> !updInProg);

  // R11: hold clears the flag
  assert_set_clears_uip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    setMode |=> !updInProg);

  // R9: under hold the bytes move only through writes
  assert_set_holds_fields_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (setMode && !wrEn) |=> ($stable(secReg) && $stable(minReg) && $stable(hourReg) &&
                            $stable(dowReg) && $stable(domReg) && $stable(monReg) &&
                            $stable(yearReg)));

  // R10: alarm-match only with update-ended
  assert_alarm_with_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alarmHit |-> updEnded);

endmodule

bind rtc_cal_top rtc_cal_chk #(.RUN_CODE(RUN_CODE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .secTick   (secTick),
  .oscSel    (oscSel),
  .setMode   (setMode),
  .wrEn      (wrEn),
  .secReg    (secReg),
  .minReg    (minReg),
  .hourReg   (hourReg),
  .dowReg    (dowReg),
  .domReg    (domReg),
  .monReg    (monReg),
  .yearReg   (yearReg),
  .updInProg (updInProg),
  .updEnded  (updEnded),
  .alarmHit  (alarmHit)
);

// File: tb/tb_rtc_cal_top.sv
`timescale 1ns/1ps
module tb_rtc_cal_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       secTick = 1'b0;
  logic       baseTick = 1'b0;
  logic [2:0] oscSel = 3'b010;
  logic       binMode = 1'b0;
  logic       hr24Mode = 1'b1;
  logic       setMode = 1'b0;
  logic       wrEn = 1'b0;
  logic [3:0] wrSel = 4'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] secReg, minReg, hourReg, dowReg, domReg, monReg, yearReg;
  logic       updInProg, updEnded, alarmHit;

  int checks = 0;
  int errors = 0;
  int m[7];
  int alm[3];
  int seedDummy;

  always #2.5 clk = ~clk;

  rtc_cal_top dut (
    .clk(clk), .rst_n(rst_n), .secTick(secTick), .baseTick(baseTick),
    .oscSel(oscSel), .binMode(binMode), .hr24Mode(hr24Mode), .setMode(setMode),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .secReg(secReg), .minReg(minReg), .hourReg(hourReg), .dowReg(dowReg),
    .domReg(domReg), .monReg(monReg), .yearReg(yearReg),
    .updInProg(updInProg), .updEnded(updEnded), .alarmHit(alarmHit)
  );

  function automatic int encV(int v, bit bin);
    return bin ? v : (((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int encH(int h, bit bin, bit h24);
    if (h24) return encV(h, bin);
    return encV(h % 12, bin) | ((h >= 12) ? 128 : 0);
  endfunction

  function automatic int expField(int i);
    return (i == 2) ? encH(m[2], binMode, hr24Mode) : encV(m[i], binMode);
  endfunction

  function automatic int dutField(int i);
    case (i)
      0: return int'(secReg);
      1: return int'(minReg);
      2: return int'(hourReg);
      3: return int'(dowReg);
      4: return int'(domReg);
      5: return int'(monReg);
      default: return int'(yearReg);
    endcase
  endfunction

  function automatic int daysIn(int mo, int yr);
    int full;
    bit leap;
    full = 2000 + yr;
    leap = (full % 4 == 0) && ((full % 100 != 0) || (full % 400 == 0));
    if (mo == 2) return leap ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic bit almExp();
    bit ok = 1'b1;
    for (int k = 0; k < 3; k++)
      if (!(((alm[k] >> 6) == 3) || (alm[k] == expField(k)))) ok = 1'b0;
    return ok;
  endfunction

  task automatic stepModel();
    m[0]++;
    if (m[0] == 60) begin
      m[0] = 0; m[1]++;
      if (m[1] == 60) begin
        m[1] = 0; m[2]++;
        if (m[2] == 24) begin
          m[2] = 0;
          m[3] = (m[3] + 1) % 7;
          m[4]++;
          if (m[4] > daysIn(m[5], m[6])) begin
            m[4] = 1; m[5]++;
            if (m[5] > 12) begin
              m[5] = 1;
              m[6] = (m[6] + 1) % 100;
            end
          end
        end
      end
    end
  endtask

  task automatic checkVal(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic checkFields(string req);
    for (int i = 0; i < 7; i++)
      checkVal($sformatf("%s field %0d", req, i), dutField(i), expField(i));
  endtask

  task automatic hostWrite(int sel, int data);
    wrEn = 1'b1; wrSel = 4'(sel); wrData = 8'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseSec();
    secTick = 1'b1;
    @(negedge clk);
    secTick = 1'b0;
  endtask

  task automatic pulseBase(int n);
    for (int i = 0; i < n; i++) begin
      baseTick = 1'b1;
      @(negedge clk);
    end
    baseTick = 1'b0;
  endtask

  task automatic loadTime(int s, int mi, int h, int dw, int dm, int mo, int y, string req);
    m[0] = s; m[1] = mi; m[2] = h; m[3] = dw; m[4] = dm; m[5] = mo; m[6] = y;
    setMode = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 7; i++) hostWrite(i, expField(i));
    setMode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    checkFields(req);
  endtask

  task automatic setAlarms(int a0, int a1, int a2);
    alm[0] = a0; alm[1] = a1; alm[2] = a2;
    for (int k = 0; k < 3; k++) hostWrite(8 + k, alm[k]);
  endtask

  task automatic runSecond(bit expAdv, string req);
    bit expAlm;
    pulseSec();
    checkVal({req, " R3 flag after tick"}, int'(updInProg), int'(expAdv));
    pulseBase(8);
    if (expAdv) stepModel();
    expAlm = expAdv && almExp();
    checkVal({req, " R3 update-ended"}, int'(updEnded), int'(expAdv));
    checkVal({req, " R3 flag cleared"}, int'(updInProg), 0);
    checkVal({req, " R10 alarm"}, int'(alarmHit), int'(expAlm));
    checkFields(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    seedDummy = $urandom(32'd20240611);
    m = '{0, 0, 0, 0, 1, 1, 0};
    alm = '{0, 0, 0};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checkFields("R1");
    checkVal("R1 flag", int'(updInProg), 0);
    checkVal("R1 ended", int'(updEnded), 0);
    checkVal("R1 alarm", int'(alarmHit), 0);

    setAlarms(8'hC0, 8'h00, 8'h00);
    // R2: halted divider skips ticks
    oscSel = 3'b110;
    runSecond(1'b0, "R2 halted");
    oscSel = 3'b010;
    runSecond(1'b1, "R2 running");

    // R6: full rollover chain, BCD 24h (R4)
    loadTime(59, 59, 23, 6, 31, 12, 99, "R6 load");
    runSecond(1'b1, "R6 year wrap");
    checkVal("R6 year byte", int'(yearReg), 8'h00);
    checkVal("R4 BCD day byte", int'(domReg), 8'h01);

    // R7: leap rules
    loadTime(59, 59, 23, 2, 28, 2, 24, "R7 load 2024");
    runSecond(1'b1, "R7 leap 2024");
    checkVal("R7 Feb 29", int'(domReg), 8'h29);
    loadTime(59, 59, 23, 2, 28, 2, 23, "R7 load 2023");
    runSecond(1'b1, "R7 common 2023");
    checkVal("R7 March", int'(monReg), 8'h03);
    loadTime(59, 59, 23, 2, 28, 2, 0, "R7 load 2000");
    runSecond(1'b1, "R7 leap 2000");
    checkVal("R7 Feb 29 of 2000", int'(domReg), 8'h29);

    // R8: out-of-range month has 31 days
    loadTime(59, 59, 23, 1, 30, 13, 5, "R8 load");
    runSecond(1'b1, "R8 month 13");
    checkVal("R8 day 31", int'(domReg), 8'h31);

    // R5: 12-hour form, BCD then binary
    hr24Mode = 1'b0;
    loadTime(59, 59, 11, 0, 10, 6, 10, "R5 load");
    runSecond(1'b1, "R5 noon");
    checkVal("R5 noon byte", int'(hourReg), 8'h80);
    loadTime(59, 59, 23, 0, 10, 6, 10, "R5 load pm");
    checkVal("R5 11 pm byte", int'(hourReg), 8'h91);
    runSecond(1'b1, "R5 midnight");
    checkVal("R5 midnight byte", int'(hourReg), 8'h00);
    binMode = 1'b1;
    loadTime(58, 59, 23, 3, 15, 7, 42, "R4 binary load");
    checkVal("R5 binary 11 pm", int'(hourReg), 8'h8B);
    checkVal("R4 binary seconds", int'(secReg), 8'h3A);
    runSecond(1'b1, "R4 binary");
    binMode = 1'b0;
    hr24Mode = 1'b1;

    // R9: hold keeps writes out of the counter until release
    loadTime(10, 20, 8, 1, 5, 5, 30, "R9 load");
    setMode = 1'b1;
    @(negedge clk);
    hostWrite(0, 8'h30);
    m[0] = 30;
    runSecond(1'b0, "R9 held");
    setMode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    runSecond(1'b1, "R9 released");
    checkVal("R9 seconds from held byte", int'(secReg), 8'h31);
    hostWrite(0, 8'h45);
    m[0] = 45;
    @(negedge clk);
    runSecond(1'b1, "R9 live write");
    checkVal("R9 live write seconds", int'(secReg), 8'h46);

    // R10: alarm match and mismatch
    loadTime(29, 20, 10, 1, 5, 5, 30, "R10 load");
    setAlarms(8'h30, 8'hC0, 8'h10);
    runSecond(1'b1, "R10 match");
    checkVal("R10 alarm hit", int'(alarmHit), 1);
    runSecond(1'b1, "R10 miss");
    checkVal("R10 alarm quiet", int'(alarmHit), 0);

    // R11: raising hold clears the flag, bytes stay
    pulseSec();
    setMode = 1'b1;
    @(negedge clk);
    checkVal("R11 flag cleared by hold", int'(updInProg), 0);
    pulseBase(8);
    checkFields("R11 held bytes");
    setMode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    runSecond(1'b1, "R11 resume");

    // R12: tick inside an open window is dropped
    pulseSec();
    pulseBase(3);
    pulseSec();
    pulseBase(5);
    stepModel();
    checkVal("R12 ended", int'(updEnded), 1);
    checkFields("R12 single advance");

    // Random scenarios near rollover points (R4 R5 R6 R7 R10)
    for (int sc = 0; sc < 40; sc++) begin
      int y, mo, dm;
      binMode  = 1'($urandom % 2);
      hr24Mode = 1'($urandom % 2);
      y  = int'($urandom % 100);
      mo = 1 + int'($urandom % 12);
      dm = daysIn(mo, y) - int'($urandom % 2);
      loadTime(57 + int'($urandom % 3), 58 + int'($urandom % 2), 22 + int'($urandom % 2),
               int'($urandom % 7), dm, mo, y, "R6 random load");
      setAlarms(($urandom % 2) ? 8'hC0 : encV(int'($urandom % 4), binMode),
                ($urandom % 2) ? 8'hC0 : encV(int'($urandom % 60), binMode),
                ($urandom % 2) ? 8'hC0 : encH(int'($urandom % 24), binMode, hr24Mode));
      for (int s = 0; s < 6; s++) runSecond(1'b1, "R6 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule